// File: doc/BRIEF.md
# Typed Predicate Define Unit

This block executes the compare-and-define operations of a predicated processor. It owns a small file of one-bit predicate registers. An operation arrives with its integer operands already read. A define operation compares the two operands under a selectable condition, and a guard predicate qualifies the result. The unit then writes up to two destination predicates. Each destination has its own write type and its own sense.

An unconditional destination is always overwritten. An OR-type destination can only be driven to one, and an AND-type destination can only be driven to zero. A chain of defines can therefore build a disjunction or a conjunction of several compares in one predicate without any branch. Explicit clear and set operations prepare those accumulators. Predicate 0 always reads as true, so it serves as the guard for operations that must always execute.

The operation port follows valid/ready. `op_ready` is held high, so the unit never applies back-pressure and accepts one operation on every cycle in which `op_valid` is high. The whole predicate file is visible on `pred_vec`.

Top module: `pred_define_unit`

## Requirements
- R1: After reset, `pred_vec` bit 0 is 1 and every other bit is 0.
- R2: Predicate 0 always reads 1. Any clear, set or define that targets index 0 leaves it at 1.
- R3: `op_cond` selects the comparison of `op_a` against `op_b`. The encodings are: 0 eq, 1 ne, 2 signed lt, 3 signed le, 4 signed gt, 5 signed ge, 6 unsigned lt, 7 unsigned le, 8 unsigned gt, 9 unsigned ge. Codes 10 to 15 evaluate false.
- R4: With `op_kind`=0 (define), a destination of type 0 (unconditional) is written with guard AND sense. The guard is the predicate named by `op_guard`. The sense is the compare result, inverted when that destination's invert bit is 1.
- R5: A destination of type 1 (OR-type) is written to 1 when guard AND sense is true, and is otherwise left unchanged.
- R6: A destination of type 2 (AND-type) is written to 0 when the guard is true and the sense is false, and is otherwise left unchanged.
- R7: Each destination has its own invert bit, so one define can write the true sense to one predicate and the complemented sense to another.
- R8: When both destinations name the same register and both update it, the second destination's value is the one that remains.
- R9: `op_kind`=1 clears the predicate at `op_dst0` to 0, and `op_kind`=2 sets it to 1, regardless of the guard. Kind 3 and destination type 3 write nothing.
- R10: An operation is accepted on a rising edge when `op_valid` is high. Its effect shows on `pred_vec` after that edge. The guard reads the value from before the edge. With `op_valid` low, `pred_vec` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation present |
| op_ready | output | 1 | Always 1; unit accepts every cycle |
| op_kind | input | 2 | 0 define, 1 clear, 2 set, 3 none |
| op_cond | input | 4 | Compare condition code |
| op_a | input | W | First integer operand |
| op_b | input | W | Second integer operand |
| op_guard | input | log2(N) | Guard predicate index |
| op_dst0 | input | log2(N) | First destination index (also target of clear/set) |
| op_type0 | input | 2 | First destination write type |
| op_inv0 | input | 1 | First destination invert |
| op_dst1 | input | log2(N) | Second destination index |
| op_type1 | input | 2 | Second destination write type |
| op_inv1 | input | 1 | Second destination invert |
| pred_vec | output | N | Current predicate file contents |

## Verification
The bound assertions check several properties on every cycle. Predicate 0 stays true. An idle cycle leaves the file untouched. A define whose two destinations are both OR-type never clears a bit, and one whose two destinations are both AND-type never sets a bit. Clear, set and an unconditional write under a false guard each land on the following cycle. Only the bench scenarios can show the rest. The exact truth table of every signed and unsigned condition needs them, as does the accumulation of multi-term conditions over chains of defines. They also cover the invert bit, the precedence of the second destination, and the use of a guard value written by the operation just before.

// File: rtl/pdu_pkg.sv
package pdu_pkg;
  typedef enum logic [1:0] {
    OP_DEFINE = 2'd0,
    OP_CLEAR  = 2'd1,
    OP_SET    = 2'd2,
    OP_NONE   = 2'd3
  } op_kind_e;

  typedef enum logic [1:0] {
    WT_UNCOND = 2'd0,
    WT_OR     = 2'd1,
    WT_AND    = 2'd2,
    WT_HOLD   = 2'd3
  } wtype_e;

  localparam logic [3:0] C_EQ  = 4'd0;
  localparam logic [3:0] C_NE  = 4'd1;
  localparam logic [3:0] C_SLT = 4'd2;
  localparam logic [3:0] C_SLE = 4'd3;
  localparam logic [3:0] C_SGT = 4'd4;
  localparam logic [3:0] C_SGE = 4'd5;
  localparam logic [3:0] C_ULT = 4'd6;
  localparam logic [3:0] C_ULE = 4'd7;
  localparam logic [3:0] C_UGT = 4'd8;
  localparam logic [3:0] C_UGE = 4'd9;

  typedef struct packed {
    logic en;
    logic val;
  } pwrite_t;
endpackage

// File: rtl/pdu_compare.sv
module pdu_compare #(
  parameter int W = 32
) (
  input  logic [3:0]   cond,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         hit
);
  import pdu_pkg::*;

  logic eq, lt_s, lt_u;

  always_comb begin
    eq   = (a == b);
    lt_u = (a < b);
    lt_s = ($signed(a) < $signed(b));
  end

  always_comb begin
    unique case (cond)
      C_EQ:    hit = eq;
      C_NE:    hit = !eq;
      C_SLT:   hit = lt_s;
      C_SLE:   hit = lt_s | eq;
      C_SGT:   hit = !(lt_s | eq);
      C_SGE:   hit = !lt_s;
      C_ULT:   hit = lt_u;
      C_ULE:   hit = lt_u | eq;
      C_UGT:   hit = !(lt_u | eq);
      C_UGE:   hit = !lt_u;
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/pdu_dest_rule.sv
module pdu_dest_rule (
  input  logic              accept,
  input  logic [1:0]        kind,
  input  logic [1:0]        wtype,
  input  logic              guard,
  input  logic              sense,
  output pdu_pkg::pwrite_t  wr
);
  import pdu_pkg::*;

  always_comb begin
    wr = '{en: 1'b0, val: 1'b0};
    if (accept) begin
      unique case (op_kind_e'(kind))
        OP_DEFINE: begin
          unique case (wtype_e'(wtype))
            WT_UNCOND: wr = '{en: 1'b1, val: guard & sense};
            WT_OR:     wr = '{en: guard & sense, val: 1'b1};
            WT_AND:    wr = '{en: guard & ~sense, val: 1'b0};
            default:   wr = '{en: 1'b0, val: 1'b0};
          endcase
        end
        OP_CLEAR: wr = '{en: 1'b1, val: 1'b0};
        OP_SET:   wr = '{en: 1'b1, val: 1'b1};
        default:  wr = '{en: 1'b0, val: 1'b0};
      endcase
    end
  end
endmodule

// File: rtl/pdu_pred_file.sv
module pdu_pred_file #(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IW-1:0]    idx0,
  input  pdu_pkg::pwrite_t wr0,
  input  logic [IW-1:0]    idx1,
  input  pdu_pkg::pwrite_t wr1,
  output logic [N-1:0]     q
);
  assign q[0] = 1'b1;

  for (genvar i = 1; i < N; i++) begin : g_bit
    logic hit0, hit1, nxt, r;
    always_comb begin
      hit0 = wr0.en && (idx0 == IW'(i));
      hit1 = wr1.en && (idx1 == IW'(i));
      if (hit1)      nxt = wr1.val;
      else if (hit0) nxt = wr0.val;
      else           nxt = r;
    end
    always_ff @(posedge clk) begin
      if (!rst_n) r <= 1'b0;
      else        r <= nxt;
    end
    assign q[i] = r;
  end
endmodule

// File: rtl/pred_define_unit.sv
module pred_define_unit #(
  parameter int W = 32,
  parameter int N = 16,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  output logic          op_ready,
  input  logic [1:0]    op_kind,
  input  logic [3:0]    op_cond,
  input  logic [W-1:0]  op_a,
  input  logic [W-1:0]  op_b,
  input  logic [IW-1:0] op_guard,
  input  logic [IW-1:0] op_dst0,
  input  logic [1:0]    op_type0,
  input  logic          op_inv0,
  input  logic [IW-1:0] op_dst1,
  input  logic [1:0]    op_type1,
  input  logic          op_inv1,
  output logic [N-1:0]  pred_vec
);
  import pdu_pkg::*;

  logic    accept, hit, guard, is_define;
  pwrite_t wr0, wr1;

  assign op_ready  = 1'b1;
  assign accept    = op_valid & op_ready;
  assign guard     = pred_vec[op_guard];
  assign is_define = (op_kind == OP_DEFINE);

  pdu_compare #(.W(W)) u_cmp (
    .cond(op_cond), .a(op_a), .b(op_b), .hit(hit)
  );

  pdu_dest_rule u_rule0 (
    .accept(accept), .kind(op_kind), .wtype(op_type0),
    .guard(guard), .sense(hit ^ op_inv0), .wr(wr0)
  );

  pdu_dest_rule u_rule1 (
    .accept(accept & is_define), .kind(op_kind), .wtype(op_type1),
    .guard(guard), .sense(hit ^ op_inv1), .wr(wr1)
  );

  pdu_pred_file #(.N(N), .IW(IW)) u_file (
    .clk(clk), .rst_n(rst_n),
    .idx0(op_dst0), .wr0(wr0),
    .idx1(op_dst1), .wr1(wr1),
    .q(pred_vec)
  );
endmodule

// File: rtl/pred_define_unit_chk.sv
module pred_define_unit_chk #(
  parameter int W = 32,
  parameter int N = 16,
  localparam int IW = $clog2(N)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          op_valid,
  input logic [1:0]    op_kind,
  input logic [IW-1:0] op_guard,
  input logic [IW-1:0] op_dst0,
  input logic [1:0]    op_type0,
  input logic [IW-1:0] op_dst1,
  input logic [1:0]    op_type1,
  input logic [N-1:0]  pred_vec
);
  AST_P0_TRUE: assert property (@(posedge clk) disable iff (!rst_n)
    pred_vec[0]); // R2

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(pred_vec)); // R10

  AST_OR_NEVER_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_kind == 2'd0 && op_type0 == 2'd1 && op_type1 == 2'd1)
    |=> ((pred_vec & $past(pred_vec)) == $past(pred_vec))); // R5

  AST_AND_NEVER_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_kind == 2'd0 && op_type0 == 2'd2 && op_type1 == 2'd2)
    |=> ((pred_vec | $past(pred_vec)) == $past(pred_vec))); // R6

  AST_CLEAR_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_kind == 2'd1 && op_dst0 != '0)
    |=> !pred_vec[$past(op_dst0)]); // R9

  AST_SET_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_kind == 2'd2) |=> pred_vec[$past(op_dst0)]); // R9

  AST_UNCOND_FALSE_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_kind == 2'd0 && op_type1 == 2'd0 && op_dst1 != '0
     && !pred_vec[op_guard])
    |=> !pred_vec[$past(op_dst1)]); // R4
endmodule

bind pred_define_unit pred_define_unit_chk #(.W(W), .N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
  .op_guard(op_guard), .op_dst0(op_dst0), .op_type0(op_type0),
  .op_dst1(op_dst1), .op_type1(op_type1), .pred_vec(pred_vec)
);

// File: tb/tb_pred_define_unit.sv
module tb_pred_define_unit;
  localparam int  W = 32;
  localparam int  N = 16;
  localparam int  IW = $clog2(N);
  localparam time PERIOD = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          op_valid = 1'b0;
  logic          op_ready;
  logic [1:0]    op_kind = '0;
  logic [3:0]    op_cond = '0;
  logic [W-1:0]  op_a = '0, op_b = '0;
  logic [IW-1:0] op_guard = '0, op_dst0 = '0, op_dst1 = '0;
  logic [1:0]    op_type0 = 2'd3, op_type1 = 2'd3;
  logic          op_inv0 = 1'b0, op_inv1 = 1'b0;
  logic [N-1:0]  pred_vec;

  int    compared = 0;
  int    failed = 0;
  bit    done = 0;
  bit    mdl [N];
  string cur_tag = "R1";

  always #(PERIOD/2) clk = ~clk;

  pred_define_unit #(.W(W), .N(N)) dut (.*);

  function automatic bit eval(int c, logic [W-1:0] a, logic [W-1:0] b);
    longint sa = longint'($signed(a));
    longint sb = longint'($signed(b));
    longint ua = longint'({1'b0, a});
    longint ub = longint'({1'b0, b});
    case (c)
      0: return ua == ub;
      1: return ua != ub;
      2: return sa < sb;
      3: return sa <= sb;
      4: return sa > sb;
      5: return sa >= sb;
      6: return ua < ub;
      7: return ua <= ub;
      8: return ua > ub;
      9: return ua >= ub;
      default: return 0;
    endcase
  endfunction

  function automatic void mdl_write(int idx, int t, bit g, bit s);
    if (idx == 0) return;
    if (t == 0) mdl[idx] = g & s;
    else if (t == 1 && g && s) mdl[idx] = 1;
    else if (t == 2 && g && !s) mdl[idx] = 0;
  endfunction

  task automatic step();
    logic [N-1:0] exp;
    @(negedge clk);
    for (int i = 0; i < N; i++) exp[i] = mdl[i];
    compared++;
    if (pred_vec !== exp) begin
      failed++;
      $display("FAIL %s: pred_vec=%h expected %h", cur_tag, pred_vec, exp);
    end
  endtask

  task automatic issue(int kind, int c, logic [W-1:0] a, logic [W-1:0] b,
                       int g, int d0, int t0, bit i0, int d1, int t1, bit i1,
                       string tag);
    bit gv, r;
    op_valid = 1; op_kind = 2'(kind); op_cond = 4'(c); op_a = a; op_b = b;
    op_guard = IW'(g); op_dst0 = IW'(d0); op_type0 = 2'(t0); op_inv0 = i0;
    op_dst1 = IW'(d1); op_type1 = 2'(t1); op_inv1 = i1;
    gv = mdl[g];
    r  = eval(c, a, b);
    if (kind == 0) begin
      mdl_write(d0, t0, gv, r ^ i0);
      mdl_write(d1, t1, gv, r ^ i1);
    end else if (kind == 1 && d0 != 0) mdl[d0] = 0;
    else if (kind == 2 && d0 != 0) mdl[d0] = 1;
    cur_tag = tag;
    step();
  endtask

  task automatic idle(string tag);
    op_valid = 0;
    cur_tag = tag;
    step();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, failed);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    failed++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finish_run();
  end

  initial begin
    for (int i = 0; i < N; i++) mdl[i] = (i == 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle("R1 reset state");
    if (op_ready !== 1'b1) begin
      failed++;
      $display("FAIL R10: op_ready=%b expected 1", op_ready);
    end
    compared++;

    // R9 clear / set, kind 3 no effect
    issue(2, 0, 0, 0, 0, 5, 3, 0, 0, 3, 0, "R9 set p5");
    issue(2, 0, 0, 0, 0, 3, 3, 0, 0, 3, 0, "R9 set p3");
    issue(1, 0, 0, 0, 0, 5, 3, 0, 0, 3, 0, "R9 clear p5");
    issue(3, 0, 0, 0, 0, 3, 0, 0, 3, 0, 0, "R9 kind3 none");
    // R2 writes to p0 ignored
    issue(1, 0, 0, 0, 0, 0, 3, 0, 0, 3, 0, "R2 clear p0");
    issue(0, 1, 1, 1, 0, 0, 0, 0, 0, 0, 1, "R2 define p0");
    // R4 unconditional, R7 invert
    issue(0, 0, 7, 7, 0, 4, 0, 0, 6, 0, 1, "R4 R7 uncond eq");
    issue(0, 1, 7, 7, 0, 6, 0, 1, 10, 0, 0, "R7 invert ne");
    issue(0, 0, 7, 7, 7, 4, 0, 0, 11, 0, 1, "R4 false guard");
    // R5 OR accumulation
    issue(1, 0, 0, 0, 0, 8, 3, 0, 0, 3, 0, "R5 clear p8");
    issue(0, 0, 1, 2, 0, 8, 1, 0, 8, 1, 0, "R5 or false");
    issue(0, 0, 2, 2, 0, 8, 1, 0, 12, 1, 0, "R5 or true");
    issue(0, 0, 1, 2, 0, 8, 1, 0, 12, 1, 0, "R5 or stays");
    issue(0, 0, 3, 3, 7, 13, 1, 0, 14, 1, 0, "R5 or guard false");
    // R6 AND accumulation
    issue(2, 0, 0, 0, 0, 9, 3, 0, 0, 3, 0, "R6 set p9");
    issue(0, 0, 3, 3, 0, 9, 2, 0, 9, 2, 0, "R6 and true");
    issue(0, 0, 3, 4, 0, 9, 2, 0, 3, 2, 1, "R6 and false");
    issue(0, 0, 3, 3, 0, 9, 2, 0, 9, 2, 0, "R6 and stays");
    issue(0, 0, 3, 4, 7, 3, 2, 0, 12, 2, 0, "R6 and guard false");
    // R3 signed vs unsigned
    issue(0, 2, '1, 1, 0, 1, 0, 0, 2, 0, 0, "R3 slt");
    issue(0, 6, '1, 1, 0, 1, 0, 0, 2, 0, 0, "R3 ult");
    issue(0, 8, '1, 1, 0, 1, 0, 0, 2, 0, 0, "R3 ugt");
    issue(0, 4, '1, 1, 0, 2, 0, 0, 1, 0, 0, "R3 sgt");
    issue(0, 12, 5, 5, 0, 1, 0, 0, 2, 0, 1, "R3 unused code");
    // R8 same destination, second wins
    issue(0, 0, 9, 9, 0, 15, 0, 0, 15, 0, 1, "R8 same dst");
    issue(0, 0, 9, 9, 0, 15, 0, 1, 15, 0, 0, "R8 same dst rev");
    issue(0, 0, 9, 8, 0, 15, 0, 0, 15, 3, 0, "R8 hold second");
    // R10 guard from previous op, idle no change
    issue(2, 0, 0, 0, 0, 7, 3, 0, 0, 3, 0, "R10 set guard");
    issue(0, 0, 1, 1, 7, 13, 0, 0, 14, 0, 1, "R10 guard just set");
    op_kind = 2'd2; op_dst0 = 4'd5;
    idle("R10 idle ignored");
    // random mix
    for (int n = 0; n < 600; n++) begin
      issue(int'($urandom_range(0, 3)), int'($urandom_range(0, 15)),
            ($urandom_range(0, 3) == 0) ? W'($urandom_range(0, 3)) : W'($urandom),
            ($urandom_range(0, 3) == 0) ? W'($urandom_range(0, 3)) : W'($urandom),
            int'($urandom_range(0, N-1)), int'($urandom_range(0, N-1)),
            int'($urandom_range(0, 3)), 1'($urandom),
            int'($urandom_range(0, N-1)), int'($urandom_range(0, 3)),
            1'($urandom), "R3 random mix");
      if (n % 50 == 0) idle("R10 random idle");
    end
    finish_run();
  end
endmodule